// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

The engine moves outgoing frame data from memory to a byte stream. Software builds a circular ring of 32-byte descriptors. Each descriptor names one data segment by its byte address and length. The engine walks the ring from a current pointer. For every descriptor it does not find in software's hands, it sends that segment one byte per accepted beat, then writes the descriptor's control word back with the ownership bit set so that software can reclaim the slot. A frame may span several descriptors. Flags in each descriptor mark the segment that opens a frame and the segment that closes it. Each descriptor also carries a 5-bit port map, which travels with every byte of its segment.

Software loads a ring base address and a starting pointer while the engine is stopped, then pulses a kick input. The engine scans until it reaches a descriptor still owned by software, and then stops. A kick that arrives while the engine is working is remembered, so that the stop point is scanned once more. A suspend level input stops the engine from fetching further descriptors for as long as it is held.

The control flow is one state machine with these states:
- IDLE: stopped.
- SCAN: issue the read of the control word.
- OWN: test the ownership bit.
- PTR: take the data pointer and request the port-map word.
- MAP: take the port map.
- WORD: read a data word.
- LOAD: latch that data word.
- BYTE: offer bytes on the stream.
- WBACK: write the control word back and advance the pointer.

Its transitions are:
- kick: IDLE to SCAN.
- fetch: SCAN to OWN, taken when suspend is low.
- stop: OWN to IDLE when software owns the descriptor and no kick is pending; with a kick pending, OWN returns to SCAN instead (rescan).
- accept: OWN to PTR to MAP.
- empty: MAP to WBACK when the length is zero.
- load: MAP to WORD, and WORD to LOAD to BYTE.
- refill: BYTE to WORD when a word boundary is crossed.
- done: BYTE to WBACK after the final byte.
- next: WBACK to SCAN.

Top module: `txr_tx_ring_dma`

## Requirements
- R1: After reset the engine is idle. No memory request and no stream beat is issued, and the current pointer reads 0.
- R2: A write to the base or pointer register is taken only while the engine is idle. While it is scanning or sending, such writes are ignored and the current pointer keeps its value.
- R3: A kick while idle starts a scan at the current pointer. A descriptor at byte address A holds the data pointer at A+0, the control word at A+4 and the port-map word at A+8, inside a 32-byte slot. In the control word, bits [15:0] are the length, bit 28 is last-segment, bit 29 is first-segment, bit 30 is end-of-ring and bit 31 is ownership.
- R4: The bytes of a segment appear in ascending address order from any starting alignment. Byte k of a data word is bits [8k+7:8k]. Every byte carries the port map from bits [22:18] of the port-map word.
- R5: tx_first is high on the first byte of a segment whose first-segment bit is set. tx_last is high on the final byte of a segment whose last-segment bit is set. A frame may span several descriptors.
- R6: After the final byte of a segment is accepted, the control word is written back with bit 31 set and all other bits unchanged.
- R7: After write-back, the current pointer advances by 32. If the descriptor had end-of-ring set, it loads the base address instead.
- R8: A descriptor whose bit 31 is 1 stops the engine. No further memory access occurs until the next kick, and the pointer stays on that descriptor.
- R9: A kick received while the engine is busy is remembered. On reaching a descriptor owned by software, the engine reads that control word once more before it stops.
- R10: While suspend is high, no control word is fetched. Fetching resumes when suspend falls.
- R11: A segment of length zero produces no stream beat, but it is still written back and the pointer still advances.
- R12: While tx_valid is high and tx_ready is low, tx_data, tx_first, tx_last and tx_pmap hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| kick | input | 1 | Start or restart scanning |
| base_we | input | 1 | Load ring base from reg_wdata |
| ptr_we | input | 1 | Load current pointer from reg_wdata |
| reg_wdata | input | AW | Register write data |
| suspend | input | 1 | Hold off descriptor fetch |
| cur_ptr | output | AW | Current descriptor pointer |
| dm_rd | output | 1 | Descriptor word read |
| dm_wr | output | 1 | Descriptor word write |
| dm_addr | output | AW | Descriptor word byte address |
| dm_wdata | output | 32 | Descriptor write data |
| dm_rdata | input | 32 | Descriptor read data, one cycle after dm_rd |
| sm_rd | output | 1 | Segment data word read |
| sm_addr | output | AW | Segment word byte address (aligned) |
| sm_rdata | input | 32 | Segment read data, one cycle after sm_rd |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of frame |
| tx_last | output | 1 | Last byte of frame |
| tx_pmap | output | 5 | Destination port map |

## Verification
A byte counter that is off by one shows at the stream within one segment: a byte is added or missing, or tx_last lands on the wrong byte. An unaligned start address exposes a wrong byte select at once. A wrong end-of-ring or advance decision shows in cur_ptr, and in the address of the next control-word read, one cycle after write-back. A lost kick-pending flag shows only as one missing control-word read at the stop point. The bench therefore counts reads at that exact address.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int DESC_BYTES = 32;
    localparam int OFS_PTR    = 0;
    localparam int OFS_CTRL   = 4;
    localparam int OFS_MAP    = 8;
    localparam int BIT_OWN    = 31;
    localparam int BIT_EOR    = 30;
    localparam int BIT_FIRST  = 29;
    localparam int BIT_LAST   = 28;
    localparam int MAP_LSB    = 18;
    localparam int MAP_W      = 5;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SCAN, ST_OWN, ST_PTR, ST_MAP,
        ST_WORD, ST_LOAD, ST_BYTE, ST_WBACK
    } txr_state_e;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_ld,
    input  logic          ptr_ld,
    input  logic [AW-1:0] wdata,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] cur_q
);
    import txr_pkg::*;
    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            if (base_ld)
                base_q <= wdata;
            if (ptr_ld)
                cur_q <= wdata;
            else if (advance)
                cur_q <= wrap ? base_q : cur_q + STEP;
        end
    end
endmodule

// File: rtl/txr_seg_walk.sv
module txr_seg_walk #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] start_len,
    input  logic          step,
    output logic [AW-1:0] byte_addr,
    output logic          seg_first,
    output logic          last_byte,
    output logic          word_end
);
    logic [LW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_addr <= '0;
            remain    <= '0;
            seg_first <= 1'b0;
        end else if (start) begin
            byte_addr <= start_addr;
            remain    <= start_len;
            seg_first <= 1'b1;
        end else if (step) begin
            byte_addr <= byte_addr + AW'(1);
            remain    <= remain - LW'(1);
            seg_first <= 1'b0;
        end
    end

    assign last_byte = (remain == LW'(1));
    assign word_end  = (byte_addr[1:0] == 2'b11);
endmodule

// File: rtl/txr_tx_ring_dma.sv
module txr_tx_ring_dma #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick,
    input  logic          base_we,
    input  logic          ptr_we,
    input  logic [AW-1:0] reg_wdata,
    input  logic          suspend,
    output logic [AW-1:0] cur_ptr,
    output logic          dm_rd,
    output logic          dm_wr,
    output logic [AW-1:0] dm_addr,
    output logic [31:0]   dm_wdata,
    input  logic [31:0]   dm_rdata,
    output logic          sm_rd,
    output logic [AW-1:0] sm_addr,
    input  logic [31:0]   sm_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_first,
    output logic          tx_last,
    output logic [4:0]    tx_pmap
);
    import txr_pkg::*;

    txr_state_e       state, nxt;
    logic [31:0]      ctrl_q;
    logic [MAP_W-1:0] pmap_q;
    logic [31:0]      word_q;
    logic             kick_pend;
    logic [AW-1:0]    base_q;
    logic [AW-1:0]    byte_addr;
    logic             seg_first, last_byte, word_end;
    logic             own_sw;
    logic [LW-1:0]    seg_len;

    assign own_sw  = dm_rdata[BIT_OWN];
    assign seg_len = ctrl_q[LW-1:0];

    txr_ring_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_ld (base_we && state == ST_IDLE),
        .ptr_ld  (ptr_we && state == ST_IDLE),
        .wdata   (reg_wdata),
        .advance (state == ST_WBACK),
        .wrap    (ctrl_q[BIT_EOR]),
        .base_q  (base_q),
        .cur_q   (cur_ptr)
    );

    txr_seg_walk #(.AW(AW), .LW(LW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (state == ST_PTR),
        .start_addr (dm_rdata[AW-1:0]),
        .start_len  (seg_len),
        .step       (state == ST_BYTE && tx_ready),
        .byte_addr  (byte_addr),
        .seg_first  (seg_first),
        .last_byte  (last_byte),
        .word_end   (word_end)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (kick) nxt = ST_SCAN;
            ST_SCAN:  if (!suspend) nxt = ST_OWN;
            ST_OWN:   nxt = own_sw ? ((kick_pend || kick) ? ST_SCAN : ST_IDLE) : ST_PTR;
            ST_PTR:   nxt = ST_MAP;
            ST_MAP:   nxt = (seg_len == '0) ? ST_WBACK : ST_WORD;
            ST_WORD:  nxt = ST_LOAD;
            ST_LOAD:  nxt = ST_BYTE;
            ST_BYTE:  if (tx_ready) nxt = last_byte ? ST_WBACK : (word_end ? ST_WORD : ST_BYTE);
            ST_WBACK: nxt = ST_SCAN;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs per state
    always_comb begin
        dm_rd    = 1'b0;
        dm_wr    = 1'b0;
        dm_addr  = cur_ptr;
        dm_wdata = ctrl_q | (32'd1 << BIT_OWN);
        sm_rd    = 1'b0;
        tx_valid = 1'b0;
        unique case (state)
            ST_SCAN: begin
                dm_rd   = !suspend;
                dm_addr = cur_ptr + AW'(OFS_CTRL);
            end
            ST_OWN: begin
                dm_rd   = !own_sw;
                dm_addr = cur_ptr + AW'(OFS_PTR);
            end
            ST_PTR: begin
                dm_rd   = 1'b1;
                dm_addr = cur_ptr + AW'(OFS_MAP);
            end
            ST_WORD:  sm_rd = 1'b1;
            ST_BYTE:  tx_valid = 1'b1;
            ST_WBACK: begin
                dm_wr   = 1'b1;
                dm_addr = cur_ptr + AW'(OFS_CTRL);
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            pmap_q    <= '0;
            word_q    <= '0;
            kick_pend <= 1'b0;
        end else begin
            if (state == ST_OWN)  ctrl_q <= dm_rdata;
            if (state == ST_MAP)  pmap_q <= dm_rdata[MAP_LSB +: MAP_W];
            if (state == ST_LOAD) word_q <= sm_rdata;
            if (state == ST_IDLE || (state == ST_OWN && own_sw))
                kick_pend <= 1'b0;
            else if (kick)
                kick_pend <= 1'b1;
        end
    end

    assign sm_addr  = {byte_addr[AW-1:2], 2'b00};
    assign tx_data  = word_q[8*byte_addr[1:0] +: 8];
    assign tx_first = tx_valid && seg_first && ctrl_q[BIT_FIRST];
    assign tx_last  = tx_valid && last_byte && ctrl_q[BIT_LAST];
    assign tx_pmap  = pmap_q;
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
    parameter int AW = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                suspend,
    input logic [AW-1:0]       cur_ptr,
    input logic [AW-1:0]       base_q,
    input logic                dm_rd,
    input logic                dm_wr,
    input logic [AW-1:0]       dm_addr,
    input logic                sm_rd,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic [7:0]          tx_data,
    input logic                tx_first,
    input logic                tx_last,
    input logic [4:0]          tx_pmap,
    input txr_pkg::txr_state_e state
);
    import txr_pkg::*;

    assert_hold_stream_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_first)
                                     && $stable(tx_last) && $stable(tx_pmap)));

    assert_suspend_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_rd && dm_addr[4:0] == 5'(OFS_CTRL)) |-> !suspend);

    assert_writeback_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> dm_wr);

    assert_pointer_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dm_wr |=> (cur_ptr == base_q || cur_ptr == $past(cur_ptr) + AW'(DESC_BYTES)));

    assert_stream_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (!dm_rd && !dm_wr && !sm_rd));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!dm_rd && !dm_wr && !sm_rd && !tx_valid));
endmodule

bind txr_tx_ring_dma txr_checker #(.AW(AW)) u_txr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .suspend  (suspend),
    .cur_ptr  (cur_ptr),
    .base_q   (base_q),
    .dm_rd    (dm_rd),
    .dm_wr    (dm_wr),
    .dm_addr  (dm_addr),
    .sm_rd    (sm_rd),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_first (tx_first),
    .tx_last  (tx_last),
    .tx_pmap  (tx_pmap),
    .state    (state)
);

// File: tb/test_txr_tx_ring_dma.sv
`timescale 1ns/1ps
module test_txr_tx_ring_dma;
    localparam int AW = 32;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] EOR = 32'h4000_0000;
    localparam logic [31:0] FST = 32'h2000_0000;
    localparam logic [31:0] LST = 32'h1000_0000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0, kick = 1'b0, base_we = 1'b0, ptr_we = 1'b0, suspend = 1'b0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] cur_ptr, dm_addr, sm_addr;
    logic          dm_rd, dm_wr, sm_rd, tx_valid, tx_ready, tx_first, tx_last;
    logic [31:0]   dm_wdata, dm_rdata, sm_rdata;
    logic [7:0]    tx_data;
    logic [4:0]    tx_pmap;
    logic          rdy_en = 1'b1, tgl_on = 1'b0, tgl = 1'b0;

    assign tx_ready = rdy_en & (tgl_on ? tgl : 1'b1);
    always @(posedge clk) #1 tgl = ~tgl;

    txr_tx_ring_dma #(.AW(AW)) i_txr_tx_ring_dma (
        .clk(clk), .rst_n(rst_n), .kick(kick), .base_we(base_we), .ptr_we(ptr_we),
        .reg_wdata(reg_wdata), .suspend(suspend), .cur_ptr(cur_ptr),
        .dm_rd(dm_rd), .dm_wr(dm_wr), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_rdata(dm_rdata), .sm_rd(sm_rd), .sm_addr(sm_addr), .sm_rdata(sm_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last), .tx_pmap(tx_pmap)
    );

    logic [31:0] mem [0:255];
    always @(posedge clk) begin
        if (dm_wr) mem[dm_addr[9:2]] <= dm_wdata;
        if (dm_rd) dm_rdata <= mem[dm_addr[9:2]];
        if (sm_rd) sm_rdata <= mem[sm_addr[9:2]];
    end

    typedef struct packed {
        logic [7:0] d;
        logic       f;
        logic       l;
        logic [4:0] m;
    } beat_t;
    beat_t exp_q[$];

    int total = 0, bad = 0, beats = 0, rd44 = 0, rd_any = 0;
    bit done = 1'b0;

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    logic       pv = 1'b0, pr = 1'b0;
    logic [7:0] pd = '0;
    always @(negedge clk) if (rst_n) begin
        if (dm_rd && dm_addr == 32'h44) rd44++;
        if (dm_rd || dm_wr || sm_rd) rd_any++;
        if (pv && !pr)
            chk(tx_valid && tx_data == pd, "R12 held beat", {23'd0, tx_valid, tx_data}, {24'd1, pd});
        if (tx_valid && tx_ready) begin
            beats++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected beat", {24'd0, tx_data}, 32'd0);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                chk(tx_data == e.d && tx_first == e.f && tx_last == e.l && tx_pmap == e.m,
                    "R4_R5 stream beat",
                    {17'd0, tx_pmap, tx_first, tx_last, tx_data},
                    {17'd0, e.m, e.f, e.l, e.d});
            end
        end
        pv = tx_valid; pr = tx_ready; pd = tx_data;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_desc(input int slot, input logic [31:0] ptr, input logic [31:0] ctl, input logic [4:0] m);
        mem[slot >> 2]       = ptr;
        mem[(slot + 4) >> 2] = ctl;
        mem[(slot + 8) >> 2] = 32'(m) << 18;
    endtask

    task automatic push_seg(input int ptr, input int len, input bit f, input bit l, input logic [4:0] m);
        for (int i = 0; i < len; i++)
            exp_q.push_back({pat(ptr + i), f && i == 0, l && i == len - 1, m});
    endtask

    task automatic do_kick();
        kick = 1'b1; tick(1); kick = 1'b0;
    endtask

    task automatic wait_ptr(input logic [31:0] e);
        int n = 0;
        while (cur_ptr !== e && n < 2000) begin tick(1); n++; end
        tick(10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int b0;
        for (int w = 0; w < 256; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(!tx_valid && !dm_rd && !dm_wr && !sm_rd, "R1 quiet after reset",
            {28'd0, tx_valid, dm_rd, dm_wr, sm_rd}, 32'd0);
        chk(cur_ptr == 0, "R1 pointer after reset", cur_ptr, 32'd0);

        // R2 loads while idle
        reg_wdata = 32'h40; base_we = 1'b1; tick(1); base_we = 1'b0;
        ptr_we = 1'b1; tick(1); ptr_we = 1'b0;
        chk(cur_ptr == 32'h40, "R2 pointer load while idle", cur_ptr, 32'h40);

        // R3 R4 R5: two-descriptor frame, unaligned start
        set_desc(32'h40, 32'h201, FST | 32'd6, 5'd5);
        set_desc(32'h60, 32'h210, LST | 32'd3, 5'd5);
        set_desc(32'h80, 32'h0, OWN, 5'd0);
        push_seg(32'h201, 6, 1, 0, 5'd5);
        push_seg(32'h210, 3, 0, 1, 5'd5);
        do_kick();
        wait_ptr(32'h80);
        chk(cur_ptr == 32'h80, "R3 scan from loaded pointer", cur_ptr, 32'h80);
        chk(exp_q.size() == 0, "R5 frame fully sent", exp_q.size(), 0);
        chk(mem[32'h44 >> 2] == (OWN | FST | 32'd6), "R6 write-back first descriptor",
            mem[32'h44 >> 2], OWN | FST | 32'd6);
        chk(mem[32'h64 >> 2] == (OWN | LST | 32'd3), "R6 write-back second descriptor",
            mem[32'h64 >> 2], OWN | LST | 32'd3);
        rd_any = 0;
        tick(20);
        chk(rd_any == 0, "R8 stopped on software-owned slot", rd_any, 0);
        chk(cur_ptr == 32'h80, "R8 pointer stays on stop slot", cur_ptr, 32'h80);

        // R7 end-of-ring with R12 back-pressure
        set_desc(32'h80, 32'h220, FST | LST | EOR | 32'd4, 5'd1);
        push_seg(32'h220, 4, 1, 1, 5'd1);
        tgl_on = 1'b1;
        do_kick();
        wait_ptr(32'h40);
        tgl_on = 1'b0;
        chk(cur_ptr == 32'h40, "R7 wrap to base", cur_ptr, 32'h40);
        chk(exp_q.size() == 0, "R12 segment complete under stalls", exp_q.size(), 0);

        // R11 zero-length segment
        set_desc(32'h40, 32'h300, FST | LST, 5'd2);
        b0 = beats;
        do_kick();
        wait_ptr(32'h60);
        chk(beats == b0, "R11 no beats for empty segment", beats, b0);
        chk(mem[32'h44 >> 2] == (OWN | FST | LST), "R11 empty segment written back",
            mem[32'h44 >> 2], OWN | FST | LST);
        chk(cur_ptr == 32'h60, "R11 pointer advanced", cur_ptr, 32'h60);

        // R10 suspend, R2 writes ignored while busy
        suspend = 1'b1;
        set_desc(32'h60, 32'h243, FST | LST | 32'd5, 5'd16);
        push_seg(32'h243, 5, 1, 1, 5'd16);
        rd_any = 0;
        do_kick();
        tick(10);
        chk(rd_any == 0, "R10 no fetch while suspended", rd_any, 0);
        reg_wdata = 32'h100; ptr_we = 1'b1; tick(1); ptr_we = 1'b0;
        reg_wdata = 32'h0; base_we = 1'b1; tick(1); base_we = 1'b0;
        chk(cur_ptr == 32'h60, "R2 pointer write ignored while busy", cur_ptr, 32'h60);
        suspend = 1'b0;
        wait_ptr(32'h80);
        chk(exp_q.size() == 0, "R10 resumes after suspend", exp_q.size(), 0);
        chk(cur_ptr == 32'h80, "R10 pointer after resume", cur_ptr, 32'h80);

        // R9 kick while busy causes one rescan
        rdy_en = 1'b0;
        set_desc(32'h80, 32'h230, FST | LST | EOR | 32'd2, 5'd3);
        push_seg(32'h230, 2, 1, 1, 5'd3);
        rd44 = 0;
        do_kick();
        tick(10);
        do_kick();
        tick(3);
        rdy_en = 1'b1;
        wait_ptr(32'h40);
        chk(rd44 == 2, "R9 pending kick rescans stop slot", rd44, 2);
        chk(exp_q.size() == 0, "R4 segment after stall", exp_q.size(), 0);
        chk(cur_ptr == 32'h40, "R7_R2 wrap uses unchanged base", cur_ptr, 32'h40);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule